// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block sits between an internal bus master and an external-bus sequencer. It checks every requested address against six programmable windows. Each window holds a 16-bit base value and a 16-bit don't-care mask, both compared with the upper half of the address. It also holds an enable flag and a write-protect flag. For each request the block reports, one clock later, one of three results: a single one-hot chip-select, a no-match indication, or an error. The error tells the sequencer to end the access on the internal bus and start no external cycle.

Configuration arrives over a simple write port. A window index and a register-kind bit pick either the window's base register or its mask register. Decoding always uses the configuration that was in force before the clock edge on which the request is sampled.

Top module: `cs_window_decoder`

## Requirements
- R1: With a mask of zero, a valid window matches only when address bits 31..16 equal its base exactly. Address bits 15..0 never affect the decode.
- R2: A mask bit of 1 (mask register bits 31..16) makes the corresponding address bit a don't-care. A mask bit of 0 requires that address bit to equal the base bit (base register bits 31..16).
- R3: A window decodes only when its enable flag (mask register bit 0) is 1. After reset every register is zero, so every request reports no-match.
- R4: A write whose winning window has its protect flag set (mask register bit 8) raises `bus_err` and drives no chip-select.
- R5: A read that hits a protected window selects that window normally, with `bus_err` low.
- R6: When several valid windows match, only the lowest-numbered one is selected. `cs_sel` bit i stands for window i and is always one-hot or zero.
- R7: A request that matches no valid window raises `no_hit` with `cs_sel` zero and `bus_err` low.
- R8: Results appear on the outputs in the cycle after the clock edge that samples `req`. Each result lasts one cycle for each request, and exactly one of select, no-match or error is shown for each request. In a cycle that follows an edge with `req` low, all outputs are zero.
- R9: A configuration write with `cfg_kind`=0 loads the base register and one with `cfg_kind`=1 loads the mask register. Writes to an index of 6 or more are ignored. A request sampled on the same edge as a write decodes against the old contents.
- R10: Reset (synchronous, active low) clears all outputs and all window registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request strobe |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write access, 0 = read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Target window index |
| cfg_kind | input | 1 | 0 = base register, 1 = mask register |
| cfg_wdata | input | 32 | Configuration write data |
| cs_sel | output | 6 | One-hot chip-select result |
| no_hit | output | 1 | Request matched no valid window |
| bus_err | output | 1 | Protected write, no external cycle |

## Verification
A configuration write and a request can land on the same clock edge. The bench provokes this by enabling a window in the very cycle a request addresses it. It expects no-match for that request and a select for a repeat of it one cycle later. The protect and priority functions also meet in one decode. An address covered by both a protected low window and an unprotected high window is issued as a write and then as a read. The write must yield only the error, and the read only the low window's select.

// File: rtl/cswd_pkg.sv
// Package: shared types and register field positions for the window decoder.
// Assumes a 32-bit configuration word and comparison on the upper 16 address bits.
package cswd_pkg;
    localparam int CMP_W     = 16;  // compared address slice width
    localparam int FIELD_LSB = 16;  // base / mask field lsb in config word
    localparam int EN_BIT    = 0;   // enable flag in mask register
    localparam int PROT_BIT  = 8;   // write-protect flag in mask register

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
        logic             en;
        logic             prot;
    } win_cfg_t;
endpackage

// File: rtl/cswd_cfg_regs.sv
// Module: per-window configuration storage.
// Holds base, mask, enable and protect for each window. Writes to an index
// beyond the window count are dropped. Assumes cfg_wdata is 32 bits.
module cswd_cfg_regs
    import cswd_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int IDX_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [IDX_W-1:0]           cfg_win,
    input  logic                       cfg_kind,
    input  logic [31:0]                cfg_wdata,
    output win_cfg_t [NUM_WIN-1:0]     win_cfg
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[15:PROT_BIT+1], cfg_wdata[PROT_BIT-1:EN_BIT+1]};

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        // Load the selected register of window i on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_cfg[i] <= '0;
            end else if (cfg_we && (cfg_win == IDX_W'(i))) begin
                if (!cfg_kind) begin
                    win_cfg[i].base <= cfg_wdata[FIELD_LSB +: CMP_W];
                end else begin
                    win_cfg[i].mask <= cfg_wdata[FIELD_LSB +: CMP_W];
                    win_cfg[i].en   <= cfg_wdata[EN_BIT];
                    win_cfg[i].prot <= cfg_wdata[PROT_BIT];
                end
            end
        end
    end
endmodule

// File: rtl/cswd_win_match.sv
// Module: single-window masked compare.
// Combinational. Hit when the window is enabled and every address bit in the
// compared slice either equals the base bit or is masked as don't-care.
module cswd_win_match
    import cswd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  win_cfg_t           cfg,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic               prot
);
    logic [CMP_W-1:0] diff;
    logic             unused_low;

    assign unused_low = ^addr[ADDR_W-CMP_W-1:0];

    // Bitwise mismatch restricted to cared-for bits.
    always_comb begin
        diff = (addr[ADDR_W-1 -: CMP_W] ^ cfg.base) & ~cfg.mask;
        hit  = cfg.en && (diff == '0);
        prot = cfg.prot;
    end
endmodule

// File: rtl/cswd_prio_pick.sv
// Module: lowest-index priority pick over window hits.
// Combinational. Isolates the lowest set hit bit and reports that window's
// protect flag. Assumes at least one window.
module cswd_prio_pick #(
    parameter int NUM_WIN = 6
) (
    input  logic [NUM_WIN-1:0] hits,
    input  logic [NUM_WIN-1:0] prots,
    output logic [NUM_WIN-1:0] grant,
    output logic               any_hit,
    output logic               grant_prot
);
    // Two's-complement isolate of the lowest set bit.
    always_comb begin
        grant      = hits & (~hits + NUM_WIN'(1));
        any_hit    = |hits;
        grant_prot = |(grant & prots);
    end
endmodule

// File: rtl/cs_window_decoder.sv
// Module: top of the masked chip-select decoder.
// Decodes a requested address against NUM_WIN windows and registers one of
// select / no-match / error one clock after the request. Assumes req is a
// single-cycle strobe per access (back-to-back strobes are allowed).
module cs_window_decoder
    import cswd_pkg::*;
#(
    parameter int NUM_WIN = 6,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_win,
    input  logic               cfg_kind,
    input  logic [31:0]        cfg_wdata,
    output logic [NUM_WIN-1:0] cs_sel,
    output logic               no_hit,
    output logic               bus_err
);
    win_cfg_t [NUM_WIN-1:0] win_cfg;
    logic [NUM_WIN-1:0]     hits;
    logic [NUM_WIN-1:0]     prots;
    logic [NUM_WIN-1:0]     grant;
    logic                   any_hit;
    logic                   grant_prot;
    logic                   blocked;

    cswd_cfg_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_kind  (cfg_kind),
        .cfg_wdata (cfg_wdata),
        .win_cfg   (win_cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        cswd_win_match #(.ADDR_W(ADDR_W)) u_match (
            .cfg  (win_cfg[i]),
            .addr (req_addr),
            .hit  (hits[i]),
            .prot (prots[i])
        );
    end

    cswd_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hits       (hits),
        .prots      (prots),
        .grant      (grant),
        .any_hit    (any_hit),
        .grant_prot (grant_prot)
    );

    // A write that lands on a protected winner is turned into an error.
    assign blocked = any_hit && req_write && grant_prot;

    // Register the per-request result; idle cycles give all-zero outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sel  <= '0;
            no_hit  <= 1'b0;
            bus_err <= 1'b0;
        end else if (req) begin
            cs_sel  <= blocked ? '0 : grant;
            no_hit  <= !any_hit;
            bus_err <= blocked;
        end else begin
            cs_sel  <= '0;
            no_hit  <= 1'b0;
            bus_err <= 1'b0;
        end
    end
endmodule

// File: rtl/cswd_checker.sv
// Module: port-level property checker for the window decoder, bound to the top.
module cswd_checker #(
    parameter int NUM_WIN = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               req_write,
    input logic [NUM_WIN-1:0] cs_sel,
    input logic               no_hit,
    input logic               bus_err
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_sel)); // R6
    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> (cs_sel == '0)); // R4
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) no_hit |-> (cs_sel == '0) && !bus_err); // R7
    AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) (req && !req_write) |=> !bus_err); // R5
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) req |=> ($countones(cs_sel) + 32'(no_hit) + 32'(bus_err)) == 1); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req |=> (cs_sel == '0) && !no_hit && !bus_err); // R8
endmodule

bind cs_window_decoder cswd_checker #(.NUM_WIN(NUM_WIN)) u_cswd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_write (req_write),
    .cs_sel    (cs_sel),
    .no_hit    (no_hit),
    .bus_err   (bus_err)
);

// File: tb/cs_window_decoder_tb_top.sv
`timescale 1ns/1ps
module cs_window_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic        cfg_kind = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  cs_sel;
    logic        no_hit;
    logic        bus_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cs_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_write(req_write), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .cs_sel(cs_sel),
        .no_hit(no_hit), .bus_err(bus_err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [5:0]  sel;
        logic        miss;
        logic        err;
        logic [3:0]  rq;
    } vec_t;

    // Window map: W0 2000/0000 prot; W1 2000/00FF; W2 4000/0F00;
    // W3 6000 disabled; W4 8000/0001 prot; W5 FFFF/0000.
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h2000_0010, 1'b0, 6'b000001, 1'b0, 1'b0, 4'd6},  // R6 W0 beats W1
        '{32'h2000_0010, 1'b1, 6'b000000, 1'b0, 1'b1, 4'd4},  // R4 protected write
        '{32'h2001_0000, 1'b1, 6'b000010, 1'b0, 1'b0, 4'd2},  // R2 masked bits
        '{32'h20FF_ABCD, 1'b0, 6'b000010, 1'b0, 1'b0, 4'd2},  // R2
        '{32'h2100_0000, 1'b0, 6'b000000, 1'b1, 1'b0, 4'd1},  // R1 cared bit differs
        '{32'h4A00_1234, 1'b1, 6'b000100, 1'b0, 1'b0, 4'd2},  // R2 middle mask
        '{32'h4001_0000, 1'b0, 6'b000000, 1'b1, 1'b0, 4'd1},  // R1
        '{32'h6000_0000, 1'b0, 6'b000000, 1'b1, 1'b0, 4'd3},  // R3 disabled window
        '{32'h8001_FFFF, 1'b0, 6'b010000, 1'b0, 1'b0, 4'd5},  // R5 protected read
        '{32'h8000_0000, 1'b1, 6'b000000, 1'b0, 1'b1, 4'd4},  // R4
        '{32'hFFFF_0000, 1'b1, 6'b100000, 1'b0, 1'b0, 4'd1},  // R1 exact
        '{32'hFFFE_FFFF, 1'b0, 6'b000000, 1'b1, 1'b0, 4'd1},  // R1 low bits ignored, upper differs
        '{32'h0000_0000, 1'b0, 6'b000000, 1'b1, 1'b0, 4'd7}   // R7
    };

    task automatic chk(input int rq, input logic [5:0] s, input logic m, input logic e);
        checks++;
        if (cs_sel !== s || no_hit !== m || bus_err !== e) begin
            failures++;
            $display("FAIL R%0d: got sel=%b miss=%b err=%b expected sel=%b miss=%b err=%b",
                     rq, cs_sel, no_hit, bus_err, s, m, e);
        end
    endtask

    task automatic cfg(input int w, input logic k, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'(w); cfg_kind = k; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Single request; result is sampled at the negedge after the capturing edge.
    task automatic access(input logic [31:0] a, input logic w);
        @(negedge clk);
        req = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req = 1'b0;
    endtask

    function automatic logic [31:0] mreg(input logic [15:0] m, input logic p, input logic v);
        return {m, 7'd0, p, 7'd0, v};
    endfunction

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(10, 6'b0, 1'b0, 1'b0);                 // R10 reset state
        rst_n = 1'b1;
        access(32'h0000_0000, 1'b0);
        chk(3, 6'b0, 1'b1, 1'b0);                  // R3 all windows off after reset

        cfg(0, 1'b0, 32'h2000_0000); cfg(0, 1'b1, mreg(16'h0000, 1'b1, 1'b1));
        cfg(1, 1'b0, 32'h2000_0000); cfg(1, 1'b1, mreg(16'h00FF, 1'b0, 1'b1));
        cfg(2, 1'b0, 32'h4000_0000); cfg(2, 1'b1, mreg(16'h0F00, 1'b0, 1'b1));
        cfg(3, 1'b0, 32'h6000_0000);
        cfg(4, 1'b0, 32'h8000_0000); cfg(4, 1'b1, mreg(16'h0001, 1'b1, 1'b1));
        cfg(5, 1'b0, 32'hFFFF_0000); cfg(5, 1'b1, mreg(16'h0000, 1'b0, 1'b1));

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr, VECS[i].wr);
            chk(int'(VECS[i].rq), VECS[i].sel, VECS[i].miss, VECS[i].err);
        end

        // R8: idle cycle after a request pulse gives zero outputs.
        @(negedge clk);
        chk(8, 6'b0, 1'b0, 1'b0);

        // R8: back-to-back requests each get their own result.
        @(negedge clk);
        req = 1'b1; req_addr = 32'hFFFF_1111; req_write = 1'b0;
        @(negedge clk);
        chk(8, 6'b100000, 1'b0, 1'b0);
        req_addr = 32'h8000_0000; req_write = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(8, 6'b000000, 1'b0, 1'b1);

        // R9: writes to index 7 are dropped.
        cfg(7, 1'b0, 32'h7000_0000); cfg(7, 1'b1, mreg(16'h0000, 1'b0, 1'b1));
        access(32'h7000_0000, 1'b0);
        chk(9, 6'b0, 1'b1, 1'b0);

        // R9: enable W3 on the same edge as a request to it: old config used.
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'd3; cfg_kind = 1'b1; cfg_wdata = mreg(16'h0000, 1'b0, 1'b1);
        req = 1'b1; req_addr = 32'h6000_0000; req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(9, 6'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(9, 6'b001000, 1'b0, 1'b0);
        req = 1'b0;

        // R9: a base write leaves the mask untouched (W2 keeps don't-care bits).
        cfg(2, 1'b0, 32'h5000_0000);
        access(32'h5300_0000, 1'b0);
        chk(9, 6'b000100, 1'b0, 1'b0);

        // R10: reset clears configuration.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(32'h2000_0010, 1'b0);
        chk(10, 6'b0, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule